// File: doc/BRIEF.md
# USB Test-Mode Control Unit

This block holds the 8-bit test-mode control register of a USB controller and carries out what its three live bits ask for. One bit latches the core into host operation for the length of a session, whatever the bus lines or the attach flag say. One bit selects full speed, which takes effect at the next bus reset; low speed is selected while it is clear. One bit starts an internal engine that moves the packet held in the endpoint-0 transmit buffer into the endpoint-0 receive buffer, so that firmware can check its FIFO path without any traffic on the cable.

Software writes the register through a simple write strobe and reads it back through a combinational read bus. The two endpoint-0 buffers are small internal FIFOs with a byte count. A producer port loads the transmit side and a consumer port drains the receive side. The host/device role input masks the host-forcing bit when the core acts as a device.

Top module: `usb_testmode_ctl`

## Requirements
- R1: Register layout: bit 7 is force-host, bit 6 is FIFO-copy, bit 5 is force-full-speed, and bits 4..0 always read 0. After reset, the register reads 0x00, all three status outputs are 0, and both buffer levels are 0.
- R2: While `role_host_i` is 0, bit 7 reads 0, a write of 1 to it has no effect, and a force-host value that is already held is dropped.
- R3: A write with one test bit set, or none, loads bit 7 and bit 5 from the written value. Bit 6 can only be set by a write. A write with two or more test bits set acts only on the winner, in the order force-host, then FIFO-copy, then force-full-speed. The winner is set and the other bits keep their previous values.
- R4: When force-host is held and `session_i` goes from 0 to 1, `forced_host_o` is 1 on the next cycle, whatever the values of `periph_attached_i`, `line_dp_i` and `line_dm_i`.
- R5: `forced_host_o` stays 1 while `session_i` stays 1, even if the peripheral goes away. It is 0 on the cycle after `session_i` is seen at 0. A later rising edge of `session_i` with force-host still held forces host again. Setting force-host in the middle of a session does not force.
- R6: `dev_connected_o` is registered one cycle after its inputs. In forced host it follows `periph_attached_i`. Otherwise it is 1 when either line is high (not SE0).
- R7: With force-full-speed clear, `full_speed_o` is 0 on the following cycle and bus resets are ignored. With the bit set, `full_speed_o` goes to 1 on the cycle after `bus_reset_i` and stays at 1 while the bit stays set.
- R8: Setting FIFO-copy moves the transmit bytes into the receive buffer, one per cycle, oldest first. Bit 6 clears by itself once the transmit buffer is empty.
- R9: A copy request with an empty transmit buffer, or with a full receive buffer, completes on the next cycle. Bytes that were not moved stay in the transmit buffer.
- R10: While bit 6 reads 1, `tx_wr_en` and `rx_rd_en` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 8 | Register write value |
| reg_rd_data | output | 8 | Register read value |
| role_host_i | input | 1 | 1 when the core acts as host |
| session_i | input | 1 | Session active |
| line_dp_i | input | 1 | D+ line state |
| line_dm_i | input | 1 | D- line state |
| periph_attached_i | input | 1 | Peripheral present flag |
| bus_reset_i | input | 1 | Bus reset event |
| forced_host_o | output | 1 | Forced host mode active |
| full_speed_o | output | 1 | 1 = full speed, 0 = low speed |
| dev_connected_o | output | 1 | Bus connection status |
| tx_wr_en | input | 1 | Push a byte into the endpoint-0 transmit buffer |
| tx_wr_data | input | 8 | Byte to push |
| tx_level_o | output | 4 | Transmit buffer byte count |
| rx_rd_en | input | 1 | Pop the head byte of the receive buffer |
| rx_rd_data_o | output | 8 | Head byte of the receive buffer |
| rx_level_o | output | 4 | Receive buffer byte count |

## Verification
The hardest case to reach from the ports is a copy that stops because the receive side is full while the transmit side still holds bytes. The bench fills the transmit buffer to depth, copies it in full so that the receive buffer is full, and then loads three more bytes before it asks for a second copy. Write priority is covered by sweeping all 256 write values in both roles, from three starting register states, against a model of the winner rule. Forced host is held through a peripheral drop and then re-entered in a second session.

// File: rtl/usb_tm_pkg.sv
package usb_tm_pkg;
  localparam int REG_W   = 8;
  localparam int BIT_FH  = 7;
  localparam int BIT_ACC = 6;
  localparam int BIT_FFS = 5;

  typedef struct packed {
    logic force_host;
    logic fifo_acc;
    logic force_fs;
  } tm_ctrl_t;
endpackage

// File: rtl/usb_tm_regs.sv
module usb_tm_regs
  import usb_tm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             role_host,
  input  logic             copy_done,
  output tm_ctrl_t         ctrl,
  output logic [REG_W-1:0] rd_data
);
  tm_ctrl_t ctrl_q, ctrl_d;
  logic     req_fh, req_acc, req_fs;
  logic [1:0] req_cnt;
  logic     unused_low_bits;

  assign unused_low_bits = ^wr_data[BIT_FFS-1:0];

  assign req_fh  = wr_data[BIT_FH] & role_host;
  assign req_acc = wr_data[BIT_ACC];
  assign req_fs  = wr_data[BIT_FFS];
  assign req_cnt = {1'b0, req_fh} + {1'b0, req_acc} + {1'b0, req_fs};

  always_comb begin
    ctrl_d = ctrl_q;
    if (copy_done) ctrl_d.fifo_acc = 1'b0;
    if (wr_en) begin
      if (req_cnt > 2'd1) begin
        if (req_fh) ctrl_d.force_host = 1'b1;
        else        ctrl_d.fifo_acc   = 1'b1;
      end else begin
        ctrl_d.force_host = req_fh;
        ctrl_d.force_fs   = req_fs;
        if (req_acc) ctrl_d.fifo_acc = 1'b1;
      end
    end
    if (!role_host) ctrl_d.force_host = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign ctrl = ctrl_q;

  always_comb begin
    rd_data          = '0;
    rd_data[BIT_FH]  = ctrl_q.force_host & role_host;
    rd_data[BIT_ACC] = ctrl_q.fifo_acc;
    rd_data[BIT_FFS] = ctrl_q.force_fs;
  end
endmodule

// File: rtl/usb_tm_role.sv
module usb_tm_role (
  input  logic clk,
  input  logic rst_n,
  input  logic force_host,
  input  logic force_fs,
  input  logic session,
  input  logic line_dp,
  input  logic line_dm,
  input  logic periph,
  input  logic bus_reset,
  output logic forced_host,
  output logic full_speed,
  output logic dev_conn
);
  logic sess_q, sess_d;
  logic forced_q, forced_d;
  logic fs_q, fs_d;
  logic conn_q, conn_d;
  logic sess_rise;

  assign sess_rise = session & ~sess_q;

  always_comb begin
    sess_d   = session;
    forced_d = session & (forced_q | (force_host & sess_rise));
    fs_d     = force_fs & (fs_q | bus_reset);
    conn_d   = forced_q ? periph : (line_dp | line_dm);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sess_q   <= 1'b0;
      forced_q <= 1'b0;
      fs_q     <= 1'b0;
      conn_q   <= 1'b0;
    end else begin
      sess_q   <= sess_d;
      forced_q <= forced_d;
      fs_q     <= fs_d;
      conn_q   <= conn_d;
    end
  end

  assign forced_host = forced_q;
  assign full_speed  = fs_q;
  assign dev_conn    = conn_q;
endmodule

// File: rtl/usb_tm_fifo.sv
module usb_tm_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] din,
  input  logic              pop,
  output logic [DATA_W-1:0] dout,
  output logic [LVL_W-1:0]  level,
  output logic              full,
  output logic              empty
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_q, wr_d, rd_q, rd_d;
  logic [LVL_W-1:0]  cnt_q, cnt_d;
  logic              do_push, do_pop;

  assign full    = (cnt_q == LVL_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_d  = do_push ? ptr_next(wr_q) : wr_q;
    rd_d  = do_pop  ? ptr_next(rd_q) : rd_q;
    cnt_d = cnt_q;
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end

  assign dout  = mem[rd_q];
  assign level = cnt_q;
endmodule

// File: rtl/usb_tm_copy.sv
module usb_tm_copy #(
  parameter int DATA_W = 8
) (
  input  logic              busy,
  input  logic              tx_empty,
  input  logic              rx_full,
  input  logic              ext_tx_push,
  input  logic [DATA_W-1:0] ext_tx_data,
  input  logic              ext_rx_pop,
  input  logic [DATA_W-1:0] tx_head,
  output logic              tx_push,
  output logic [DATA_W-1:0] tx_din,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_din,
  output logic              rx_pop,
  output logic              done
);
  logic move;

  assign move    = busy & ~tx_empty & ~rx_full;
  assign done    = busy & (tx_empty | rx_full);
  assign tx_push = ~busy & ext_tx_push;
  assign tx_din  = ext_tx_data;
  assign tx_pop  = move;
  assign rx_push = move;
  assign rx_din  = tx_head;
  assign rx_pop  = ~busy & ext_rx_pop;
endmodule

// File: rtl/usb_testmode_ctl.sv
module usb_testmode_ctl
  import usb_tm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [REG_W-1:0]  reg_wr_data,
  output logic [REG_W-1:0]  reg_rd_data,
  input  logic              role_host_i,
  input  logic              session_i,
  input  logic              line_dp_i,
  input  logic              line_dm_i,
  input  logic              periph_attached_i,
  input  logic              bus_reset_i,
  output logic              forced_host_o,
  output logic              full_speed_o,
  output logic              dev_connected_o,
  input  logic              tx_wr_en,
  input  logic [DATA_W-1:0] tx_wr_data,
  output logic [LVL_W-1:0]  tx_level_o,
  input  logic              rx_rd_en,
  output logic [DATA_W-1:0] rx_rd_data_o,
  output logic [LVL_W-1:0]  rx_level_o
);
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  tm_ctrl_t          ctrl;
  logic              copy_done;
  logic              tx_push, tx_pop, rx_push, rx_pop;
  logic [DATA_W-1:0] tx_din, tx_head, rx_din;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic              unused_flags;

  assign unused_flags = tx_full ^ rx_empty;

  usb_tm_regs regs_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (reg_wr_en),
    .wr_data   (reg_wr_data),
    .role_host (role_host_i),
    .copy_done (copy_done),
    .ctrl      (ctrl),
    .rd_data   (reg_rd_data)
  );

  usb_tm_role role_i (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .force_host  (ctrl.force_host),
    .force_fs    (ctrl.force_fs),
    .session     (session_i),
    .line_dp     (line_dp_i),
    .line_dm     (line_dm_i),
    .periph      (periph_attached_i),
    .bus_reset   (bus_reset_i),
    .forced_host (forced_host_o),
    .full_speed  (full_speed_o),
    .dev_conn    (dev_connected_o)
  );

  usb_tm_copy #(.DATA_W(DATA_W)) copy_i (
    .busy        (ctrl.fifo_acc),
    .tx_empty    (tx_empty),
    .rx_full     (rx_full),
    .ext_tx_push (tx_wr_en),
    .ext_tx_data (tx_wr_data),
    .ext_rx_pop  (rx_rd_en),
    .tx_head     (tx_head),
    .tx_push     (tx_push),
    .tx_din      (tx_din),
    .tx_pop      (tx_pop),
    .rx_push     (rx_push),
    .rx_din      (rx_din),
    .rx_pop      (rx_pop),
    .done        (copy_done)
  );

  usb_tm_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) tx_fifo_i (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .push  (tx_push),
    .din   (tx_din),
    .pop   (tx_pop),
    .dout  (tx_head),
    .level (tx_level_o),
    .full  (tx_full),
    .empty (tx_empty)
  );

  usb_tm_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) rx_fifo_i (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .push  (rx_push),
    .din   (rx_din),
    .pop   (rx_pop),
    .dout  (rx_rd_data_o),
    .level (rx_level_o),
    .full  (rx_full),
    .empty (rx_empty)
  );
endmodule

// File: rtl/usb_tm_checker.sv
module usb_tm_checker #(
  parameter int DEPTH = 8,
  parameter int LVL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr_en,
  input logic [7:0]       reg_rd_data,
  input logic             role_host_i,
  input logic             session_i,
  input logic             periph_attached_i,
  input logic             bus_reset_i,
  input logic             forced_host_o,
  input logic             full_speed_o,
  input logic             dev_connected_o,
  input logic [LVL_W-1:0] tx_level_o,
  input logic [LVL_W-1:0] rx_level_o
);
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_data[4:0] == 5'd0);

  a_r2_device_bit7_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !role_host_i |-> !reg_rd_data[7]);

  a_r5_hold_in_session: assert property (@(posedge clk) disable iff (!rst_n)
    (forced_host_o && session_i) |=> forced_host_o);

  a_r5_drop_without_session: assert property (@(posedge clk) disable iff (!rst_n)
    !session_i |=> !forced_host_o);

  a_r6_forced_conn: assert property (@(posedge clk) disable iff (!rst_n)
    forced_host_o |=> (dev_connected_o == $past(periph_attached_i)));

  a_r7_low_speed: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_data[5] |=> !full_speed_o);

  a_r7_fs_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_speed_o) |-> $past(bus_reset_i));

  a_r8_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_data[6] && tx_level_o == '0 && !reg_wr_en) |=> !reg_rd_data[6]);

  a_r9_levels_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level_o <= LVL_W'(DEPTH)) && (rx_level_o <= LVL_W'(DEPTH)));
endmodule

bind usb_testmode_ctl usb_tm_checker #(.DEPTH(DEPTH), .LVL_W(LVL_W)) chk_i (
  .clk               (clk),
  .rst_n             (rst_sync_n),
  .reg_wr_en         (reg_wr_en),
  .reg_rd_data       (reg_rd_data),
  .role_host_i       (role_host_i),
  .session_i         (session_i),
  .periph_attached_i (periph_attached_i),
  .bus_reset_i       (bus_reset_i),
  .forced_host_o     (forced_host_o),
  .full_speed_o      (full_speed_o),
  .dev_connected_o   (dev_connected_o),
  .tx_level_o        (tx_level_o),
  .rx_level_o        (rx_level_o)
);

// File: tb/usb_testmode_ctl_tb_top.sv
module usb_testmode_ctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic [7:0] reg_wr_data = 8'h00;
  logic [7:0] reg_rd_data;
  logic       role_host_i = 1'b1;
  logic       session_i = 1'b0;
  logic       line_dp_i = 1'b0;
  logic       line_dm_i = 1'b0;
  logic       periph_attached_i = 1'b0;
  logic       bus_reset_i = 1'b0;
  logic       forced_host_o, full_speed_o, dev_connected_o;
  logic       tx_wr_en = 1'b0;
  logic [7:0] tx_wr_data = 8'h00;
  logic [3:0] tx_level_o;
  logic       rx_rd_en = 1'b0;
  logic [7:0] rx_rd_data_o;
  logic [3:0] rx_level_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_testmode_ctl #(.DATA_W(8), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
    .role_host_i(role_host_i), .session_i(session_i),
    .line_dp_i(line_dp_i), .line_dm_i(line_dm_i),
    .periph_attached_i(periph_attached_i), .bus_reset_i(bus_reset_i),
    .forced_host_o(forced_host_o), .full_speed_o(full_speed_o),
    .dev_connected_o(dev_connected_o),
    .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data), .tx_level_o(tx_level_o),
    .rx_rd_en(rx_rd_en), .rx_rd_data_o(rx_rd_data_o), .rx_level_o(rx_level_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v);
    reg_wr_data = v;
    reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic push_tx(input logic [7:0] v);
    tx_wr_data = v;
    tx_wr_en = 1'b1;
    @(negedge clk);
    tx_wr_en = 1'b0;
  endtask

  task automatic pop_rx(output logic [7:0] v);
    v = rx_rd_data_o;
    rx_rd_en = 1'b1;
    @(negedge clk);
    rx_rd_en = 1'b0;
  endtask

  task automatic wait_copy_done();
    for (int i = 0; i < 40 && reg_rd_data[6]; i++) @(negedge clk);
  endtask

  // Write-rule model taken from R2 and R3.
  function automatic logic [7:0] model(input logic [7:0] prior, input logic [7:0] v, input bit host);
    logic fh, acc, fs, rf, ra, rs;
    int n;
    fh = prior[7]; acc = 1'b0; fs = prior[5];
    rf = v[7] & host; ra = v[6]; rs = v[5];
    n = int'(rf) + int'(ra) + int'(rs);
    if (n >= 2) begin
      if (rf) fh = 1'b1; else acc = 1'b1;
    end else begin
      fh = rf; fs = rs;
      if (ra) acc = 1'b1;
    end
    if (!host) fh = 1'b0;
    return {fh, acc, fs, 5'b0};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] prior, got, exp;
    logic [7:0] priors [3];
    priors[0] = 8'h00; priors[1] = 8'h20; priors[2] = 8'h80;

    step(3);
    rst_n = 1'b1;
    step(4);
    // R1: reset state
    chk(reg_rd_data == 8'h00, "R1 reset reg", reg_rd_data, 0);
    chk({forced_host_o, full_speed_o, dev_connected_o} == 3'b000, "R1 reset outputs",
        {forced_host_o, full_speed_o, dev_connected_o}, 0);
    chk(tx_level_o == 0 && rx_level_o == 0, "R1 reset levels", {tx_level_o, rx_level_o}, 0);

    // R1 R2 R3 R9: sweep all write values in both roles from three prior states
    for (int role = 0; role < 2; role++) begin
      role_host_i = role[0];
      for (int p = 0; p < 3; p++) begin
        for (int v = 0; v < 256; v++) begin
          prior = model(8'h00, priors[p], role[0]);
          wr(priors[p]);
          step(1);
          wr(v[7:0]);
          exp = model(prior, v[7:0], role[0]);
          chk(reg_rd_data == exp, "R3 write rule", reg_rd_data, exp);
          step(1);
          exp[6] = 1'b0;
          chk(reg_rd_data == exp, "R9 empty copy self-clears", reg_rd_data, exp);
        end
      end
    end
    chk(rx_level_o == 0, "R9 empty copy moves nothing", rx_level_o, 0);

    // R2: held force-host dropped when role becomes device
    role_host_i = 1'b1;
    wr(8'h80);
    chk(reg_rd_data == 8'h80, "R2 host role sets bit7", reg_rd_data, 8'h80);
    role_host_i = 1'b0;
    step(1);
    chk(reg_rd_data == 8'h00, "R2 device role bit7 reads 0", reg_rd_data, 0);
    role_host_i = 1'b1;
    step(1);
    chk(reg_rd_data == 8'h00, "R2 bit7 dropped in device role", reg_rd_data, 0);

    // R4 R5: forced host across sessions
    wr(8'h80);
    periph_attached_i = 1'b0; line_dp_i = 1'b0; line_dm_i = 1'b0;
    step(1);
    chk(forced_host_o == 1'b0, "R4 no force without session", forced_host_o, 0);
    session_i = 1'b1;
    step(1);
    chk(forced_host_o == 1'b1, "R4 force on session rise, no peripheral", forced_host_o, 1);
    periph_attached_i = 1'b1;
    step(2);
    periph_attached_i = 1'b0;
    step(3);
    chk(forced_host_o == 1'b1, "R5 held after disconnect", forced_host_o, 1);
    session_i = 1'b0;
    step(1);
    chk(forced_host_o == 1'b0, "R5 cleared with session", forced_host_o, 0);
    session_i = 1'b1;
    step(1);
    chk(forced_host_o == 1'b1, "R5 re-entered next session", forced_host_o, 1);
    session_i = 1'b0;
    wr(8'h00);
    step(1);
    session_i = 1'b1;
    step(1);
    wr(8'h80);
    step(2);
    chk(forced_host_o == 1'b0, "R5 mid-session set does not force", forced_host_o, 0);

    // R6: connection status
    session_i = 1'b0;
    step(1);
    line_dp_i = 1'b1; line_dm_i = 1'b0;
    step(1);
    chk(dev_connected_o == 1'b1, "R6 D+ high connected", dev_connected_o, 1);
    line_dp_i = 1'b0;
    step(1);
    chk(dev_connected_o == 1'b0, "R6 SE0 not connected", dev_connected_o, 0);
    line_dm_i = 1'b1;
    step(1);
    chk(dev_connected_o == 1'b1, "R6 D- high connected", dev_connected_o, 1);
    line_dm_i = 1'b0;
    session_i = 1'b1;
    step(1);
    periph_attached_i = 1'b1;
    step(1);
    chk(dev_connected_o == 1'b1, "R6 forced follows peripheral 1", dev_connected_o, 1);
    periph_attached_i = 1'b0; line_dp_i = 1'b1;
    step(1);
    chk(dev_connected_o == 1'b0, "R6 forced ignores lines", dev_connected_o, 0);
    line_dp_i = 1'b0; session_i = 1'b0;
    wr(8'h00);
    step(1);

    // R7: speed selection
    bus_reset_i = 1'b1;
    step(1);
    bus_reset_i = 1'b0;
    step(1);
    chk(full_speed_o == 1'b0, "R7 low speed ignores bus reset", full_speed_o, 0);
    wr(8'h20);
    step(2);
    chk(full_speed_o == 1'b0, "R7 waits for bus reset", full_speed_o, 0);
    bus_reset_i = 1'b1;
    step(1);
    bus_reset_i = 1'b0;
    chk(full_speed_o == 1'b1, "R7 full speed after bus reset", full_speed_o, 1);
    step(3);
    chk(full_speed_o == 1'b1, "R7 full speed held", full_speed_o, 1);
    wr(8'h00);
    step(1);
    chk(full_speed_o == 1'b0, "R7 back to low speed", full_speed_o, 0);

    // R8 R10: copy of five bytes, with ignored port activity during the copy
    for (int i = 0; i < 5; i++) push_tx(8'h30 + 8'(i * 7));
    chk(tx_level_o == 5, "R8 tx loaded", tx_level_o, 5);
    wr(8'h40);
    tx_wr_data = 8'hEE; tx_wr_en = 1'b1; rx_rd_en = 1'b1;
    step(2);
    tx_wr_en = 1'b0; rx_rd_en = 1'b0;
    wait_copy_done();
    chk(reg_rd_data[6] == 1'b0, "R8 copy bit self-clears", reg_rd_data, 0);
    chk(tx_level_o == 0, "R10 tx push ignored during copy", tx_level_o, 0);
    chk(rx_level_o == 5, "R10 rx pop ignored during copy", rx_level_o, 5);
    for (int i = 0; i < 5; i++) begin
      pop_rx(got);
      exp = 8'h30 + 8'(i * 7);
      chk(got == exp, "R8 byte order", got, exp);
    end

    // R9: copy into a full receive buffer
    for (int i = 0; i < DEPTH; i++) push_tx(8'(i));
    wr(8'h40);
    wait_copy_done();
    chk(rx_level_o == DEPTH, "R8 full depth copied", rx_level_o, DEPTH);
    for (int i = 0; i < 3; i++) push_tx(8'hA0 + 8'(i));
    wr(8'h40);
    step(1);
    chk(reg_rd_data[6] == 1'b0, "R9 rx full completes next cycle", reg_rd_data, 0);
    chk(tx_level_o == 3, "R9 unmoved bytes stay in tx", tx_level_o, 3);
    chk(rx_level_o == DEPTH, "R9 rx unchanged", rx_level_o, DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      pop_rx(got);
      chk(got == 8'(i), "R8 full-depth byte order", got, i);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule